// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two 8-bit ports, A and B, through two independent storage banks, one per direction of transfer. The forward bank captures what arrives at A and presents it on B; the reverse bank captures what arrives at B and presents it on A. Each direction has three active-low controls: a chip enable, a latch enable and an output enable. The chip enable gates both the capture and the drive of its direction. The latch enable opens or closes the bank. The output enable decides whether the bank's contents reach the far port.

Storage follows a clock-sampled equivalent of transparent latches. While a bank is open it takes the port value at every rising clock edge. Once it closes it keeps the last value it took. Each tri-state port is presented as a separate input vector, output vector and per-bit output-enable vector; a pad ring outside the block resolves them onto a shared wire. A contention flag rises whenever both directions would drive at once. A synchronous active-high reset clears both banks.

Top module: `latched_xcvr`

## Requirements
- R1: When the forward chip enable and forward latch enable are both low, the forward bank loads `a_in` at every rising clock edge.
- R2: With the forward chip enable low and the forward latch enable high, the forward bank keeps its value whatever `a_in` does, including right after the latch enable rises.
- R3: With the forward chip enable high, the forward bank keeps its value whatever the latch enable and `a_in` do, and `b_oe` is all zeros.
- R4: When the forward chip enable and forward output enable are both low, `b_oe` is all ones and `b_out` equals the forward bank contents; a bank update shows on `b_out` after the clock edge that loads it.
- R5: When the forward output enable is high, `b_oe` is all zeros and `b_out` is all zeros, whatever the other controls are.
- R6: The reverse direction obeys R1 to R5 with its own three controls, taking `b_in` into the reverse bank and presenting it on `a_out`/`a_oe`.
- R7: `contention` is 1 exactly when `a_oe` and `b_oe` are both driven, and 0 otherwise.
- R8: While `rst` is high at a rising edge, both banks become zero; `a_oe`, `b_oe`, `a_out`, `b_out` and `contention` are zero whenever no direction is enabled to drive.
- R9: The two banks are independent: loading one never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Value seen on the A wires |
| a_out | output | 8 | Value driven onto A (reverse bank), zero when not driven |
| a_oe | output | 8 | Per-bit drive enable for A |
| b_in | input | 8 | Value seen on the B wires |
| b_out | output | 8 | Value driven onto B (forward bank), zero when not driven |
| b_oe | output | 8 | Per-bit drive enable for B |
| ab_ce_n | input | 1 | Forward chip enable, active low |
| ab_le_n | input | 1 | Forward latch enable, active low |
| ab_oe_n | input | 1 | Forward output enable, active low |
| ba_ce_n | input | 1 | Reverse chip enable, active low |
| ba_le_n | input | 1 | Reverse latch enable, active low |
| ba_oe_n | input | 1 | Reverse output enable, active low |
| contention | output | 1 | Both ports driven at the same time |

## Verification
The assertions check on every cycle that an open bank takes the port value, that a closed or deselected bank stays unchanged, that a high output enable or chip enable silences the port, that a driven port shows its bank, and that the contention flag matches the two drive enables. Only the bench's scenarios can show whole histories end to end. These include a value frozen when the latch enable rises and then kept through later port changes. They also include data held in both directions at once, and reset clearing banks that were loaded beforehand.

// File: rtl/lxcvr_pkg.sv
package lxcvr_pkg;

    localparam int unsigned XCVR_WIDTH = 8;
    localparam int unsigned NUM_DIRS   = 2;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } dir_e;

    typedef struct packed {
        logic ce_n;
        logic le_n;
        logic oe_n;
    } dir_ctrl_t;

    function automatic logic bank_opens(input dir_ctrl_t c);
        return !c.ce_n && !c.le_n;
    endfunction

    function automatic logic port_drives(input dir_ctrl_t c);
        return !c.ce_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/lxcvr_bank.sv
module lxcvr_bank
    import lxcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (bank_opens(ctrl)) begin
            q <= din;
        end
    end

endmodule

// File: rtl/lxcvr_drive.sv
module lxcvr_drive
    import lxcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] q,
    output logic [W-1:0] dout,
    output logic [W-1:0] doe
);

    logic drive;

    always_comb begin
        drive = port_drives(ctrl);
        doe   = {W{drive}};
        dout  = drive ? q : '0;
    end

endmodule

// File: rtl/lxcvr_clash.sv
module lxcvr_clash #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] oe_x,
    input  logic [W-1:0] oe_y,
    output logic         clash
);

    assign clash = (|oe_x) && (|oe_y);

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
    import lxcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_ce_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_ce_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic         contention
);

    localparam int unsigned ND = NUM_DIRS;

    dir_ctrl_t    ctl   [ND];
    logic [W-1:0] src   [ND];
    logic [W-1:0] bank  [ND];
    logic [W-1:0] drv_d [ND];
    logic [W-1:0] drv_e [ND];

    logic [W-1:0] bank_ab;
    logic [W-1:0] bank_ba;

    assign ctl[DIR_FWD] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
    assign ctl[DIR_REV] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
    assign src[DIR_FWD] = a_in;
    assign src[DIR_REV] = b_in;

    for (genvar d = 0; d < ND; d++) begin : g_dir
        lxcvr_bank #(.W(W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctl[d]),
            .din  (src[d]),
            .q    (bank[d])
        );

        lxcvr_drive #(.W(W)) u_drive (
            .ctrl (ctl[d]),
            .q    (bank[d]),
            .dout (drv_d[d]),
            .doe  (drv_e[d])
        );
    end

    assign bank_ab = bank[DIR_FWD];
    assign bank_ba = bank[DIR_REV];

    assign b_out = drv_d[DIR_FWD];
    assign b_oe  = drv_e[DIR_FWD];
    assign a_out = drv_d[DIR_REV];
    assign a_oe  = drv_e[DIR_REV];

    lxcvr_clash #(.W(W)) u_clash (
        .oe_x  (a_oe),
        .oe_y  (b_oe),
        .clash (contention)
    );

endmodule

// File: rtl/lxcvr_checker.sv
module lxcvr_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         ab_ce_n,
    input logic         ab_le_n,
    input logic         ab_oe_n,
    input logic         ba_ce_n,
    input logic         ba_le_n,
    input logic         ba_oe_n,
    input logic         contention,
    input logic [W-1:0] bank_ab,
    input logic [W-1:0] bank_ba
);

    assert_fwd_loads_R1: assert property (@(posedge clk) disable iff (rst)
        (!ab_ce_n && !ab_le_n) |=> (bank_ab == $past(a_in)));

    assert_fwd_holds_latched_R2: assert property (@(posedge clk) disable iff (rst)
        (!ab_ce_n && ab_le_n) |=> $stable(bank_ab));

    assert_fwd_holds_deselected_R3: assert property (@(posedge clk) disable iff (rst)
        ab_ce_n |=> $stable(bank_ab));

    assert_fwd_silent_deselected_R3: assert property (@(posedge clk) disable iff (rst)
        ab_ce_n |-> (b_oe == '0));

    assert_fwd_shows_bank_R4: assert property (@(posedge clk) disable iff (rst)
        (b_oe != '0) |-> ((b_oe == '1) && (b_out == bank_ab)));

    assert_fwd_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
        ab_oe_n |-> ((b_oe == '0) && (b_out == '0)));

    assert_rev_loads_R6: assert property (@(posedge clk) disable iff (rst)
        (!ba_ce_n && !ba_le_n) |=> (bank_ba == $past(b_in)));

    assert_rev_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (ba_ce_n || ba_le_n) |=> $stable(bank_ba));

    assert_rev_oe_off_R6: assert property (@(posedge clk) disable iff (rst)
        (ba_oe_n || ba_ce_n) |-> ((a_oe == '0) && (a_out == '0)));

    assert_rev_shows_bank_R6: assert property (@(posedge clk) disable iff (rst)
        (a_oe != '0) |-> ((a_oe == '1) && (a_out == bank_ba)));

    assert_clash_flag_R7: assert property (@(posedge clk) disable iff (rst)
        contention |-> ((a_oe != '0) && (b_oe != '0)));

    assert_clash_seen_R7: assert property (@(posedge clk) disable iff (rst)
        ((a_oe != '0) && (b_oe != '0)) |-> contention);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> ((bank_ab == '0) && (bank_ba == '0)));

endmodule

bind latched_xcvr lxcvr_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_in       (b_in),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .ab_ce_n    (ab_ce_n),
    .ab_le_n    (ab_le_n),
    .ab_oe_n    (ab_oe_n),
    .ba_ce_n    (ba_ce_n),
    .ba_le_n    (ba_le_n),
    .ba_oe_n    (ba_oe_n),
    .contention (contention),
    .bank_ab    (bank_ab),
    .bank_ba    (bank_ba)
);

// File: tb/latched_xcvr_test.sv
module latched_xcvr_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int MAX_CYCLES = 200000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ab_ce_n, ab_le_n, ab_oe_n;
    logic         ba_ce_n, ba_le_n, ba_oe_n;
    logic         contention;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [W-1:0] m_ab, m_ba;

    always #(CLK_PERIOD / 2) clk = ~clk;

    latched_xcvr #(.W(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .a_in       (a_in),
        .a_out      (a_out),
        .a_oe       (a_oe),
        .b_in       (b_in),
        .b_out      (b_out),
        .b_oe       (b_oe),
        .ab_ce_n    (ab_ce_n),
        .ab_le_n    (ab_le_n),
        .ab_oe_n    (ab_oe_n),
        .ba_ce_n    (ba_ce_n),
        .ba_le_n    (ba_le_n),
        .ba_oe_n    (ba_oe_n),
        .contention (contention)
    );

    function automatic logic fwd_drives();
        return !ab_ce_n && !ab_oe_n;
    endfunction

    function automatic logic rev_drives();
        return !ba_ce_n && !ba_oe_n;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [W-1:0] e_bo, e_bd, e_ao, e_ad;
        e_bo = fwd_drives() ? '1 : '0;
        e_bd = fwd_drives() ? m_ab : '0;
        e_ao = rev_drives() ? '1 : '0;
        e_ad = rev_drives() ? m_ba : '0;
        check(req, "b_oe",  32'(b_oe),  32'(e_bo));
        check(req, "b_out", 32'(b_out), 32'(e_bd));
        check(req, "a_oe",  32'(a_oe),  32'(e_ao));
        check(req, "a_out", 32'(a_out), 32'(e_ad));
        check("R7", "contention", 32'(contention),
              32'(fwd_drives() && rev_drives()));
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_ab = '0;
            m_ba = '0;
        end else begin
            if (!ab_ce_n && !ab_le_n) m_ab = a_in;
            if (!ba_ce_n && !ba_le_n) m_ba = b_in;
        end
        @(negedge clk);
    endtask

    task automatic set_fwd(input logic ce, input logic le, input logic oe);
        ab_ce_n = ce; ab_le_n = le; ab_oe_n = oe;
    endtask

    task automatic set_rev(input logic ce, input logic le, input logic oe);
        ba_ce_n = ce; ba_le_n = le; ba_oe_n = oe;
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5A17_C0DE;
        void'($urandom(seed));
        m_ab = 'x;
        m_ba = 'x;
        rst  = 1'b1;
        a_in = 8'hA5;
        b_in = 8'h3C;
        set_fwd(1'b0, 1'b0, 1'b1);
        set_rev(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        tick();
        tick();
        // R8: reset state, nothing driven
        set_fwd(1'b1, 1'b1, 1'b1);
        set_rev(1'b1, 1'b1, 1'b1);
        #1;
        check_all("R8");
        rst = 1'b0;
        // R8: banks read zero once driven
        set_fwd(1'b0, 1'b1, 1'b0);
        set_rev(1'b0, 1'b1, 1'b0);
        tick();
        check("R8", "b_out after reset", 32'(b_out), 32'h0);
        check("R8", "a_out after reset", 32'(a_out), 32'h0);
        check_all("R8");

        // R1 / R4: transparent forward bank
        set_rev(1'b0, 1'b1, 1'b1);
        set_fwd(1'b0, 1'b0, 1'b0);
        a_in = 8'h5A;
        tick();
        check("R1", "b_out load", 32'(b_out), 32'h5A);
        a_in = 8'hC3;
        tick();
        check("R4", "b_out follows", 32'(b_out), 32'hC3);
        check_all("R4");

        // R2: latch enable rises, bank frozen
        set_fwd(1'b0, 1'b1, 1'b0);
        a_in = 8'hFF;
        tick();
        a_in = 8'h01;
        tick();
        check("R2", "b_out frozen", 32'(b_out), 32'hC3);

        // R3: deselected, latch enable ignored, port silent
        set_fwd(1'b1, 1'b0, 1'b0);
        a_in = 8'h11;
        tick();
        check("R3", "b_oe deselected", 32'(b_oe), 32'h0);
        check_all("R3");
        set_fwd(1'b0, 1'b1, 1'b0);
        tick();
        check("R3", "bank kept", 32'(b_out), 32'hC3);

        // R5: output enable high
        set_fwd(1'b0, 1'b1, 1'b1);
        tick();
        check("R5", "b_oe off", 32'(b_oe), 32'h0);
        check("R5", "b_out zero", 32'(b_out), 32'h0);

        // R6 / R7: reverse loads while forward drives
        set_fwd(1'b0, 1'b1, 1'b0);
        set_rev(1'b0, 1'b0, 1'b0);
        b_in = 8'h9E;
        tick();
        check("R6", "a_out load", 32'(a_out), 32'h9E);
        check("R7", "contention both", 32'(contention), 32'h1);
        check("R9", "fwd unaffected", 32'(b_out), 32'hC3);

        // R9: forward loads while reverse held
        set_rev(1'b0, 1'b1, 1'b0);
        set_fwd(1'b0, 1'b0, 1'b0);
        a_in = 8'h42;
        b_in = 8'h77;
        tick();
        check("R9", "rev held", 32'(a_out), 32'h9E);
        check("R9", "fwd loaded", 32'(b_out), 32'h42);
        set_rev(1'b0, 1'b1, 1'b1);
        #1;
        check("R7", "contention drops", 32'(contention), 32'h0);

        // R8: reset mid-run clears loaded banks
        rst = 1'b1;
        tick();
        rst = 1'b0;
        set_rev(1'b0, 1'b1, 1'b0);
        set_fwd(1'b0, 1'b1, 1'b0);
        tick();
        check("R8", "fwd cleared", 32'(b_out), 32'h0);
        check("R8", "rev cleared", 32'(a_out), 32'h0);

        // Random mix covering R1..R7
        for (int i = 0; i < 600; i++) begin
            rst  = ($urandom_range(0, 49) == 0);
            a_in = W'($urandom());
            b_in = W'($urandom());
            set_fwd(1'($urandom_range(0, 3) == 0), 1'($urandom()), 1'($urandom()));
            set_rev(1'($urandom_range(0, 3) == 0), 1'($urandom()), 1'($urandom()));
            tick();
            if (!rst) check_all("R1 R2 R3 R4 R5 R6");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule